// File: doc/BRIEF.md
# Flash Address Range Protection Filter

This block sits between software-visible configuration and a serial flash command engine. Before the engine issues a command, it presents the opcode, the target address and a flag that says whether the command carries an address. The filter answers in the same cycle whether the command must be suppressed. Four range registers each describe one protected window. A window is 4 KiB or 64 KiB and lies above a ROM base, and each register carries its own read-protect and write-protect flags. A write-once register names the four opcodes that are subject to filtering.

Filtering only applies once software clears the direct-access control bit. A suppressed command sets a sticky violation flag, which software clears by writing 1. Configuration is done through a simple one-cycle write port with a combinational read-back, selected by a 3-bit register select: 0 to 3 select the range registers, 4 the opcode register, 5 the control register and 6 the status register.

Top module: `flash_prot_filter`

## Requirements
- R1: After reset, every range register and the opcode register read zero, control bit 0 (direct access) reads 1, status bit 0 (violation) reads 0, and no command is blocked.
- R2: A range register holds the window index in bits 7:0, the unit in bit 8 (1 selects 64 KiB, 0 selects 4 KiB), write-protect in bit 9, read-protect in bit 10, and the ROM base in bits 31:16 (base = field × 65536). The window covers [base + index × unit, base + (index+1) × unit).
- R3: A range register whose 32 bits are all zero is unused and contributes no window and no protection.
- R4: The opcode register holds the write-enable opcode in bits 31:24, page program in 23:16, erase in 15:8 and read in 7:0. A slot holding zero matches no opcode.
- R5: The first write to the opcode register after reset is stored. Every later write is ignored until the next reset.
- R6: A program or erase opcode with an address is blocked when the address lies in any write-protected window. A read opcode with an address is blocked when the address lies in any read-protected window.
- R7: The write-enable opcode is blocked, whatever its address flag and address, whenever any used range has write-protect set.
- R8: An address below a range's ROM base never lies in that range's window. A program, erase or read opcode presented without an address is never blocked.
- R9: No command is blocked while control bit 0 is 1. Filtering acts only while it is 0.
- R10: A blocked command sets status bit 0 at the next clock. The bit holds until a write of 1 to status bit 0 clears it. If a set and a clear fall in the same cycle, the set wins.
- R11: The blocked output responds combinationally in the same cycle as the check request, and it is low whenever the check-valid input is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select for write and read-back |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the selected register |
| chk_valid | input | 1 | A command is presented for checking |
| chk_opcode | input | 8 | Opcode of the presented command |
| chk_addr | input | ADDR_W | Flash byte address of the command |
| chk_has_addr | input | 1 | The command carries an address |
| chk_blocked | output | 1 | The command must not be issued |
| viol_flag | output | 1 | Sticky violation flag |

## Verification
The assertions assume that inputs change only away from the rising edge and are stable across it. They also assume that reset is applied before any check is made, since the write-once lock and the sticky flag are only meaningful from a known start. The bench drives every input on the falling edge from tasks and holds it for a full cycle. Its stimulus includes overlapping cases: a write to the opcode register while it is locked, and a violation that coincides with a clear. These exercise the ordering properties without breaking the stable-input assumption.

// File: rtl/fpf_pkg.sv
package fpf_pkg;
    localparam int NUM_RANGES = 4;
    localparam int REG_W      = 32;
    localparam int SEL_W      = 3;

    localparam logic [SEL_W-1:0] SEL_OPC  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd5;
    localparam logic [SEL_W-1:0] SEL_STAT = 3'd6;

    typedef struct packed {
        logic [NUM_RANGES-1:0][REG_W-1:0] rng;
        logic [REG_W-1:0]                 opc;
        logic                             locked;
        logic                             direct;
        logic                             viol;
    } fpf_state_t;
endpackage

// File: rtl/fpf_range_cmp.sv
module fpf_range_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic [31:0]       rng_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic              wp_o,
    output logic              rp_o
);
    localparam int SH_SMALL = 12;
    localparam int SH_LARGE = 16;

    logic              used;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] win;

    always_comb begin
        used  = |rng_i;
        base  = ADDR_W'({rng_i[31:16], 16'h0000});
        offs  = addr_i - base;
        win   = rng_i[8] ? (offs >> SH_LARGE) : (offs >> SH_SMALL);
        hit_o = used && (addr_i >= base) && (win == ADDR_W'(rng_i[7:0]));
        wp_o  = used && rng_i[9];
        rp_o  = used && rng_i[10];
    end
endmodule

// File: rtl/fpf_opc_class.sv
module fpf_opc_class (
    input  logic [31:0] opc_i,
    input  logic [7:0]  op_i,
    output logic        is_wen_o,
    output logic        is_wr_o,
    output logic        is_rd_o
);
    logic [3:0] slot_hit;

    for (genvar s = 0; s < 4; s++) begin : g_slot
        assign slot_hit[s] = (opc_i[8*s +: 8] != 8'h00) && (opc_i[8*s +: 8] == op_i);
    end

    assign is_wen_o = slot_hit[3];
    assign is_wr_o  = slot_hit[2] | slot_hit[1];
    assign is_rd_o  = slot_hit[0];
endmodule

// File: rtl/flash_prot_filter.sv
module flash_prot_filter
    import fpf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              chk_valid,
    input  logic [7:0]        chk_opcode,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic              chk_has_addr,
    output logic              chk_blocked,
    output logic              viol_flag
);
    fpf_state_t st_d, st_q;

    logic [NUM_RANGES-1:0] hit_v, wp_v, rp_v;
    logic is_wen, is_wr, is_rd;
    logic any_wp, wp_hit, rp_hit, blk;
    logic clr_req;

    for (genvar r = 0; r < NUM_RANGES; r++) begin : g_rng
        fpf_range_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .rng_i  (st_q.rng[r]),
            .addr_i (chk_addr),
            .hit_o  (hit_v[r]),
            .wp_o   (wp_v[r]),
            .rp_o   (rp_v[r])
        );
    end

    fpf_opc_class u_cls (
        .opc_i    (st_q.opc),
        .op_i     (chk_opcode),
        .is_wen_o (is_wen),
        .is_wr_o  (is_wr),
        .is_rd_o  (is_rd)
    );

    always_comb begin
        any_wp  = |wp_v;
        wp_hit  = |(hit_v & wp_v);
        rp_hit  = |(hit_v & rp_v);
        blk     = chk_valid && !st_q.direct &&
                  ((is_wen && any_wp) ||
                   (chk_has_addr && ((is_wr && wp_hit) || (is_rd && rp_hit))));
        clr_req = cfg_we && (cfg_sel == SEL_STAT) && cfg_wdata[0];

        st_d = st_q;
        if (cfg_we) begin
            if (!cfg_sel[2]) begin
                st_d.rng[cfg_sel[1:0]] = cfg_wdata;
            end else if (cfg_sel == SEL_OPC) begin
                if (!st_q.locked) begin
                    st_d.opc    = cfg_wdata;
                    st_d.locked = 1'b1;
                end
            end else if (cfg_sel == SEL_CTRL) begin
                st_d.direct = cfg_wdata[0];
            end
        end
        if (clr_req) st_d.viol = 1'b0;
        if (blk)     st_d.viol = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.direct <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (!cfg_sel[2])               cfg_rdata = st_q.rng[cfg_sel[1:0]];
        else if (cfg_sel == SEL_OPC)   cfg_rdata = st_q.opc;
        else if (cfg_sel == SEL_CTRL)  cfg_rdata = {31'd0, st_q.direct};
        else if (cfg_sel == SEL_STAT)  cfg_rdata = {31'd0, st_q.viol};
    end

    assign chk_blocked = blk;
    assign viol_flag   = st_q.viol;

    assert_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> $stable(st_q.opc));

    assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.direct |-> !chk_blocked);

    assert_sticky_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chk_blocked |=> viol_flag);

    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && !clr_req) |=> viol_flag);

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |-> !chk_blocked);

    assert_noaddr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_has_addr && !is_wen) |-> !chk_blocked);

    assert_unused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rng == '0) |-> !chk_blocked);
endmodule

// File: tb/tb_flash_prot_filter.sv
module tb_flash_prot_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        chk_valid = 1'b0;
    logic [7:0]  chk_opcode = 8'd0;
    logic [31:0] chk_addr = 32'd0;
    logic        chk_has_addr = 1'b0;
    logic        chk_blocked;
    logic        viol_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    flash_prot_filter #(.ADDR_W(32)) dut (
        .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .cfg_rdata,
        .chk_valid, .chk_opcode, .chk_addr, .chk_has_addr,
        .chk_blocked, .viol_flag
    );

    // behavioural reference state
    logic [31:0] m_rng [4];
    logic [31:0] m_opc;
    bit          m_lock, m_direct, m_viol;

    function automatic bit in_window(logic [31:0] r, logic [31:0] a);
        longint base, unit, lo;
        if (r == 32'd0) return 0;
        base = longint'(r[31:16]) * 65536;
        unit = r[8] ? 65536 : 4096;
        lo   = base + longint'(r[7:0]) * unit;
        return (longint'(a) >= lo) && (longint'(a) < lo + unit);
    endfunction

    function automatic bit model_block(bit v, logic [7:0] op, logic [31:0] a, bit ha);
        bit wprot = 0, whit = 0, rhit = 0, res = 0;
        if (!v || m_direct) return 0;
        for (int i = 0; i < 4; i++) begin
            if (m_rng[i] != 0 && m_rng[i][9]) wprot = 1;
            if (in_window(m_rng[i], a) && m_rng[i][9])  whit = 1;
            if (in_window(m_rng[i], a) && m_rng[i][10]) rhit = 1;
        end
        if (op != 0 && op == m_opc[31:24] && wprot) res = 1;
        if (ha && op != 0 && (op == m_opc[23:16] || op == m_opc[15:8]) && whit) res = 1;
        if (ha && op != 0 && op == m_opc[7:0] && rhit) res = 1;
        return res;
    endfunction

    function automatic logic [31:0] model_read(logic [2:0] s);
        case (s)
            3'd0, 3'd1, 3'd2, 3'd3: return m_rng[s[1:0]];
            3'd4: return m_opc;
            3'd5: return {31'd0, m_direct};
            3'd6: return {31'd0, m_viol};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_rng[i] <= 32'd0;
            m_opc <= 32'd0; m_lock <= 0; m_direct <= 1; m_viol <= 0;
        end else begin
            if (cfg_we) begin
                if (cfg_sel < 3'd4) m_rng[cfg_sel[1:0]] <= cfg_wdata;
                if (cfg_sel == 3'd4 && !m_lock) begin m_opc <= cfg_wdata; m_lock <= 1; end
                if (cfg_sel == 3'd5) m_direct <= cfg_wdata[0];
            end
            if (model_block(chk_valid, chk_opcode, chk_addr, chk_has_addr)) m_viol <= 1;
            else if (cfg_we && cfg_sel == 3'd6 && cfg_wdata[0]) m_viol <= 0;
        end
    end

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit we, logic [2:0] s, logic [31:0] wd,
                        bit v, logic [7:0] op, logic [31:0] a, bit ha);
        @(negedge clk);
        cfg_we = we; cfg_sel = s; cfg_wdata = wd;
        chk_valid = v; chk_opcode = op; chk_addr = a; chk_has_addr = ha;
        #1;
        cmp(tag, "blocked", {31'd0, chk_blocked}, {31'd0, model_block(v, op, a, ha)});
        cmp(tag, "viol",    {31'd0, viol_flag},   {31'd0, m_viol});
        cmp(tag, "rdata",   cfg_rdata,            model_read(s));
    endtask

    task automatic wr(string tag, logic [2:0] s, logic [31:0] d);
        step(tag, 1, s, d, 0, 8'h00, 32'd0, 0);
    endtask

    task automatic rd(string tag, logic [2:0] s);
        step(tag, 0, s, 32'd0, 0, 8'h00, 32'd0, 0);
    endtask

    task automatic chk(string tag, logic [7:0] op, logic [31:0] a, bit ha);
        step(tag, 0, 3'd6, 32'd0, 1, op, a, ha);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        for (int s = 0; s < 7; s++) rd("R1", 3'(s));
        chk("R1", 8'h02, 32'h0, 1);
        cmp("R1", "ctrl literal", {31'd0, m_direct}, 32'd1);
        // R3: all-zero ranges give no protection even with filter on
        wr("R9", 3'd5, 32'd0);
        wr("R4", 3'd4, 32'h06022003);
        chk("R3", 8'h06, 32'h0, 0);
        chk("R3", 8'h02, 32'h0, 1);
        // R5: second write ignored
        wr("R5", 3'd4, 32'hFFFFFFFF);
        rd("R5", 3'd4);
        cmp("R5", "opc literal", cfg_rdata, 32'h06022003);
        // R2: ranges
        wr("R2", 3'd5, 32'd1);
        wr("R2", 3'd0, 32'h00FF0203);
        wr("R2", 3'd1, 32'h00000502);
        for (int s = 0; s < 2; s++) rd("R2", 3'(s));
        // R9: direct access on means nothing is blocked
        chk("R9", 8'h02, 32'h00FF3000, 1);
        chk("R9", 8'h06, 32'h0, 0);
        wr("R9", 3'd5, 32'd0);
        // R6 / R2: window edges
        for (int k = -2; k < 3; k++) begin
            chk("R6", 8'h02, 32'h00FF3000 + k, 1);
            chk("R6", 8'h20, 32'h00FF4000 + k, 1);
            chk("R6", 8'h03, 32'h00020000 + k, 1);
            chk("R6", 8'h03, 32'h00030000 + k, 1);
        end
        chk("R6", 8'h03, 32'h00FF3000, 1);
        chk("R6", 8'h02, 32'h00020000, 1);
        // R8: below base and no-address
        chk("R8", 8'h02, 32'h00003000, 1);
        chk("R8", 8'h02, 32'h00FF3000, 0);
        chk("R8", 8'h03, 32'h00020000, 0);
        // R7: write enable regardless of address
        chk("R7", 8'h06, 32'h12345678, 0);
        chk("R7", 8'h06, 32'h00000000, 1);
        // R11: valid low
        step("R11", 0, 3'd6, 0, 0, 8'h02, 32'h00FF3000, 1);
        // R10: sticky and clear
        chk("R10", 8'h02, 32'h00FF3000, 1);
        rd("R10", 3'd6);
        rd("R10", 3'd6);
        wr("R10", 3'd6, 32'd1);
        rd("R10", 3'd6);
        chk("R10", 8'h02, 32'h00FF3000, 1);
        step("R10", 1, 3'd6, 32'd1, 1, 8'h20, 32'h00FF3FFF, 1);
        rd("R10", 3'd6);
        wr("R10", 3'd6, 32'd1);
        rd("R10", 3'd6);
        // R7: write enable stays free once no range has write protect
        wr("R7", 3'd0, 32'h0);
        chk("R7", 8'h06, 32'h0, 0);
        // R5 / R4: reset unlocks; zero read slot matches nothing
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        wr("R5", 3'd4, 32'h06022000);
        rd("R5", 3'd4);
        wr("R4", 3'd1, 32'h00000502);
        wr("R4", 3'd5, 32'd0);
        chk("R4", 8'h00, 32'h00020000, 1);
        chk("R4", 8'h03, 32'h00020000, 1);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule